// File: doc/BRIEF.md
# UART FIFO Control Register with Transmit and Receive FIFOs

This block holds the write-only FIFO control register of a UART and owns the two byte queues that the register governs: one feeding the transmitter and one collecting from the receiver. A host register write sets FIFO mode, the DMA signalling mode and the receive trigger threshold. The same write can also request a flush of either queue. The serial shifters connect through plain push and pop strobes, and the pop side shows its head entry without waiting for a pop.

Bit 0 of a write is the master switch. While it is 0, the other fields of that write are discarded. Whenever the mode flips, both queues are emptied. A flush only resets a queue's pointers and occupancy. Serial shift registers sit outside the block, so a flush never reaches them. Each flush is reported on a one-cycle pulse in the cycle after the write.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, fifo_mode is 0, dma_mode is 0, rx_trig_level is 1, both counts are 0, both queues report empty, and neither flush pulse is high.
- R2: A write (wr_en high for one cycle) copies wr_data[0] into fifo_mode at that clock edge.
- R3: A write with wr_data[0]=0 leaves dma_mode and rx_trig_level unchanged, whatever the other bits hold.
- R4: A write that changes fifo_mode empties both queues and raises both rx_flush and tx_flush. A write with wr_data[0]=1 while already in FIFO mode, and with bits 1 and 2 clear, keeps both queues' contents.
- R5: Any write with wr_data[0]=0 empties both queues and pulses both flush outputs, even when FIFO mode is already off.
- R6: A write with wr_data[0]=1 and wr_data[1]=1 empties only the receive queue. rx_flush is high for exactly the one cycle after the write edge. The transmit queue keeps its contents.
- R7: A write with wr_data[0]=1 and wr_data[2]=1 empties only the transmit queue. tx_flush is high for exactly the one cycle after the write edge. The receive queue keeps its contents.
- R8: A write with wr_data[0]=1 sets dma_mode to wr_data[3].
- R9: A write with wr_data[0]=1 loads wr_data[7:6] as the trigger code: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14 bytes on rx_trig_level. rx_trig_hit is high exactly when rx_count is at least that level.
- R10: Each queue holds DEPTH (16) entries in FIFO mode and 1 entry otherwise. A push while full is ignored, and a pop while empty is ignored. The full and empty flags follow the occupancy.
- R11: Entries leave a queue in the order they entered. The pop data output shows the oldest entry whenever the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| fifo_mode | output | 1 | FIFO mode enabled |
| dma_mode | output | 1 | DMA signalling mode select |
| rx_trig_level | output | CW (5) | Receive trigger level in bytes |
| rx_trig_hit | output | 1 | Receive occupancy at or above trigger level |
| rx_flush | output | 1 | One-cycle receive flush pulse |
| tx_flush | output | 1 | One-cycle transmit flush pulse |
| tx_push | input | 1 | Transmit queue push strobe |
| tx_push_data | input | DW (8) | Transmit queue push data |
| tx_pop | input | 1 | Transmit queue pop strobe |
| tx_pop_data | output | DW (8) | Oldest transmit entry |
| tx_count | output | CW (5) | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_push | input | 1 | Receive queue push strobe |
| rx_push_data | input | DW (8) | Receive queue push data |
| rx_pop | input | 1 | Receive queue pop strobe |
| rx_pop_data | output | DW (8) | Oldest receive entry |
| rx_count | output | CW (5) | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |

## Verification
The bound checker watches several rules on every cycle. Occupancy never exceeds the capacity of the current mode. A mode-flipping write always leaves both queues empty with both pulses high. A write with bit 0 clear never disturbs the DMA or trigger settings. A rejected push or pop leaves the count unchanged. Only the directed scenarios can show data ordering, the value of each trigger level, and that a flush of one queue spares the other's contents. They also show that a mode-preserving write keeps stored bytes.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic          fifo_mode,
  output logic          dma_mode,
  output logic [CW-1:0] rx_trig_level,
  output logic          rx_trig_hit,
  output logic          rx_flush,
  output logic          tx_flush,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  output logic [CW-1:0] tx_count,
  output logic          tx_empty,
  output logic          tx_full,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_empty,
  output logic          rx_full
);
  // DEPTH must be a power of two so the pointers wrap on their own.
  logic       mode_q, dma_q, rx_fl_q, tx_fl_q;
  logic [1:0] trig_q;

  wire mode_chg = wr_en && (wr_data[0] != mode_q);
  wire rx_clr   = wr_en && (!wr_data[0] || wr_data[1] || mode_chg);
  wire tx_clr   = wr_en && (!wr_data[0] || wr_data[2] || mode_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      dma_q   <= 1'b0;
      trig_q  <= 2'd0;
      rx_fl_q <= 1'b0;
      tx_fl_q <= 1'b0;
    end else begin
      rx_fl_q <= rx_clr;
      tx_fl_q <= tx_clr;
      if (wr_en) begin
        mode_q <= wr_data[0];
        if (wr_data[0]) begin
          dma_q  <= wr_data[3];
          trig_q <= wr_data[7:6];
        end
      end
    end
  end

  assign fifo_mode = mode_q;
  assign dma_mode  = dma_q;
  assign rx_flush  = rx_fl_q;
  assign tx_flush  = tx_fl_q;

  always_comb begin
    case (trig_q)
      2'd0:    rx_trig_level = CW'(1);
      2'd1:    rx_trig_level = CW'(4);
      2'd2:    rx_trig_level = CW'(8);
      default: rx_trig_level = CW'(14);
    endcase
  end
  assign rx_trig_hit = rx_count >= rx_trig_level;

  wire [CW-1:0] cap = mode_q ? CW'(DEPTH) : CW'(1);

  // Index 0 is the transmit queue, index 1 the receive queue.
  logic [1:0]    clr_v, push_v, pop_v;
  logic [DW-1:0] din_v  [2];
  logic [DW-1:0] dout_v [2];
  logic [CW-1:0] cnt_v  [2];

  assign clr_v  = {rx_clr, tx_clr};
  assign push_v = {rx_push, tx_push};
  assign pop_v  = {rx_pop, tx_pop};
  assign din_v[0] = tx_push_data;
  assign din_v[1] = rx_push_data;

  for (genvar g = 0; g < 2; g++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    wire do_push = push_v[g] && (cnt < cap);
    wire do_pop  = pop_v[g] && (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else if (clr_v[g]) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= wp + AW'(1);
        if (do_pop)  rp <= rp + AW'(1);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end

    always_ff @(posedge clk) begin
      if (do_push && !clr_v[g]) mem[wp] <= din_v[g];
    end

    assign dout_v[g] = mem[rp];
    assign cnt_v[g]  = cnt;
  end

  assign tx_pop_data = dout_v[0];
  assign rx_pop_data = dout_v[1];
  assign tx_count    = cnt_v[0];
  assign rx_count    = cnt_v[1];
  assign tx_empty    = cnt_v[0] == '0;
  assign rx_empty    = cnt_v[1] == '0;
  assign tx_full     = cnt_v[0] >= cap;
  assign rx_full     = cnt_v[1] >= cap;
endmodule

module uart_fifo_ctl_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          fifo_mode,
  input logic          dma_mode,
  input logic [CW-1:0] rx_trig_level,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic          tx_push,
  input logic          tx_pop,
  input logic [CW-1:0] tx_count,
  input logic          tx_full,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [CW-1:0] rx_count,
  input logic          rx_empty
);
  wire [CW-1:0] lim = fifo_mode ? CW'(DEPTH) : CW'(1);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= lim) && (rx_count <= lim)); // R10
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[0] != fifo_mode)) |=>
      (tx_count == '0 && rx_count == '0 && tx_flush && rx_flush)); // R4
  AST_OFF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> ($stable(dma_mode) && $stable(rx_trig_level))); // R3
  AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> rx_count == '0); // R6
  AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> tx_count == '0); // R7
  AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop && !wr_en) |=> $stable(tx_count)); // R10
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_pop && !rx_push && !wr_en) |=> rx_count == '0); // R10
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_uart_fifo_ctl.sv
module sim_uart_fifo_ctl;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic fifo_mode, dma_mode, rx_trig_hit, rx_flush, tx_flush;
  logic [CW-1:0] rx_trig_level, tx_count, rx_count;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [DW-1:0] tx_push_data = '0, rx_push_data = '0, tx_pop_data, rx_pop_data;
  logic tx_empty, tx_full, rx_empty, rx_full;

  int checks = 0, fails = 0, cyc = 0;

  uart_fifo_ctl #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic push_tx(logic [7:0] d);
    @(negedge clk); tx_push = 1'b1; tx_push_data = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_push_data = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", fifo_mode, 0);
    chk("R1 dma", dma_mode, 0);
    chk("R1 level", rx_trig_level, 1);
    chk("R1 counts", tx_count + rx_count, 0);
    chk("R1 empty", {tx_empty, rx_empty}, 3);
    chk("R1 pulses", {tx_flush, rx_flush}, 0);
  endtask

  task automatic t_single_slot();
    push_rx(8'h11);
    push_rx(8'h22);
    chk("R10 single slot count", rx_count, 1);
    chk("R10 single slot full", rx_full, 1);
    chk("R11 single slot data", rx_pop_data, 8'h11);
    pop_rx();
    pop_rx();
    chk("R10 pop on empty", rx_count, 0);
  endtask

  task automatic t_mode_on();
    push_tx(8'h5A);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    chk("R2 mode on", fifo_mode, 1);
    chk("R4 tx flushed", tx_count, 0);
    chk("R4 pulses", {tx_flush, rx_flush}, 3);
    @(negedge clk);
    chk("R6 R7 pulse one cycle", {tx_flush, rx_flush}, 0);
  endtask

  task automatic t_keep_on_rewrite();
    push_tx(8'hA1); push_tx(8'hA2);
    push_rx(8'hB1); push_rx(8'hB2); push_rx(8'hB3);
    wr(8'h01);
    chk("R4 keep tx", tx_count, 2);
    chk("R4 keep rx", rx_count, 3);
    chk("R4 no pulse", {tx_flush, rx_flush}, 0);
  endtask

  task automatic t_rx_flush();
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h03;
    @(negedge clk); wr_en = 1'b0;
    chk("R6 rx pulse", rx_flush, 1);
    chk("R6 tx no pulse", tx_flush, 0);
    chk("R6 rx empty", rx_count, 0);
    chk("R6 tx kept", tx_count, 2);
    @(negedge clk);
    chk("R6 pulse ends", rx_flush, 0);
    chk("R11 tx head", tx_pop_data, 8'hA1);
  endtask

  task automatic t_tx_flush();
    push_rx(8'hC1);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h05;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 tx pulse", tx_flush, 1);
    chk("R7 rx no pulse", rx_flush, 0);
    chk("R7 tx empty", tx_count, 0);
    chk("R7 rx kept", rx_count, 1);
    @(negedge clk);
    chk("R7 pulse ends", tx_flush, 0);
    chk("R11 rx head", rx_pop_data, 8'hC1);
  endtask

  task automatic t_trigger();
    wr(8'h03);
    wr(8'h41);
    chk("R9 code 01", rx_trig_level, 4);
    push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
    chk("R9 below", rx_trig_hit, 0);
    push_rx(8'h04);
    chk("R9 at level", rx_trig_hit, 1);
    wr(8'h81);
    chk("R9 code 10", rx_trig_level, 8);
    chk("R9 below 8", rx_trig_hit, 0);
    wr(8'hC1);
    chk("R9 code 11", rx_trig_level, 14);
    wr(8'h01);
    chk("R9 code 00", rx_trig_level, 1);
    chk("R9 hit at 1", rx_trig_hit, 1);
  endtask

  task automatic t_dma_and_hold();
    wr(8'hC9);
    chk("R8 dma set", dma_mode, 1);
    wr(8'h40);
    chk("R2 mode off", fifo_mode, 0);
    chk("R3 dma held", dma_mode, 1);
    chk("R3 level held", rx_trig_level, 14);
    chk("R4 off flush", tx_count + rx_count, 0);
    push_tx(8'h77);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    chk("R5 flush while off", tx_count, 0);
    chk("R5 pulses while off", {tx_flush, rx_flush}, 3);
    wr(8'h01);
    wr(8'h01);
    chk("R8 dma cleared", dma_mode, 0);
  endtask

  task automatic t_capacity_order();
    for (int i = 0; i < DEPTH + 1; i++) push_tx(8'(8'h30 + i));
    chk("R10 depth", tx_count, DEPTH);
    chk("R10 full", tx_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R11 order", tx_pop_data, 8'h30 + i);
      pop_tx();
    end
    chk("R10 drained", tx_empty, 1);
    pop_tx();
    chk("R10 pop on empty", tx_count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_slot();
    t_mode_on();
    t_keep_on_rewrite();
    t_rx_flush();
    t_tx_flush();
    t_trigger();
    t_dma_and_hold();
    t_capacity_order();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule